// File: doc/BRIEF.md
# ADC Result Register Pair with Coherent Read Lock

This block holds the latest 10-bit conversion result from an analog-to-digital converter. Bus software reads it as two bytes. The low byte carries result bits 7:0. Bits 1:0 of the high byte carry result bits 9:8, and the other six high-byte bits read as zero. The converter delivers each result as a one-cycle valid pulse with the data alongside it.

Software must read the low byte first and the high byte second. A low-byte read locks the pair, so the two bytes cannot change until the high byte has been read. A result that finishes while the pair is locked is thrown away and neither byte changes. Every finished conversion still sets the completion flag, including one that was thrown away. Software clears the flag by writing a one to it. The interrupt output is the flag gated by an enable input.

The read strobes mark the cycle in which the bus samples the byte outputs. A byte output shows the register contents in the strobe's own cycle, and any update lands on the next clock edge.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both bytes read zero, the completion flag and the interrupt are low, and the pair is unlocked.
- R2: The result is right-adjusted. The low byte equals result bits 7:0, high byte bits 1:0 equal result bits 9:8, and high byte bits 7:2 are always zero.
- R3: While the pair is unlocked, a valid result appears on both byte outputs one clock after its valid pulse.
- R4: A low-byte read strobe (without a high-byte strobe) locks the pair. While it is locked, valid results are dropped and neither byte changes.
- R5: A high-byte read strobe unlocks the pair, and a result that arrives after it is accepted.
- R6: A result that arrives in the same cycle as a high-byte strobe does not change that cycle's read value, and it is stored on that clock edge.
- R7: A result that arrives in the same cycle as a low-byte strobe on an unlocked pair is dropped, because the low byte has already been sampled.
- R8: Every valid pulse sets the completion flag on the next clock, whether the result is stored or dropped.
- R9: Pulsing the clear input while the flag is high and no result arrives lowers the flag. If a result arrives in the same cycle as the clear, the flag stays set.
- R10: The interrupt output is high exactly when the flag is high and the enable input is high.
- R11: When the low-byte and high-byte strobes arrive together, the pair is left unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle pulse: a conversion has finished |
| res_data | input | 10 | Conversion result, valid with res_valid |
| rd_lo | input | 1 | Bus is reading the low byte this cycle |
| rd_hi | input | 1 | Bus is reading the high byte this cycle |
| flag_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| irq_en | input | 1 | Interrupt enable |
| lo_byte | output | 8 | Low byte of the held result |
| hi_byte | output | 8 | High byte of the held result, zero-extended |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Only the lock bit is hidden from the ports. If it sticks high, the bench sees every later result ignored after the first low-byte read, on the first valid pulse it checks. If it never sets, a result delivered between the two strobes shows up on the byte outputs one clock after its pulse. A wrong flag or wrong data mapping shows up one clock after any valid pulse. The sweep of all 1024 codes exposes any swapped or stuck data bit.

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              done_flag,
  output logic              irq
);
  localparam int HI_W  = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic [RES_W-1:0] held;
  logic             locked;
  logic             take;

  assign take = res_valid && (rd_hi || (!locked && !rd_lo));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      locked    <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (take) held <= res_data;
      if (rd_hi)      locked <= 1'b0;
      else if (rd_lo) locked <= 1'b1;
      if (res_valid)     done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end

  assign lo_byte = held[BYTE_W-1:0];
  assign hi_byte = {{PAD_W{1'b0}}, held[RES_W-1:BYTE_W]};
  assign irq     = done_flag & irq_en;
endmodule

module adc_result_latch_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              flag_clr,
  input logic              locked,
  input logic [BYTE_W-1:0] lo_byte,
  input logic [BYTE_W-1:0] hi_byte,
  input logic              done_flag
);
  localparam int HI_W = RES_W - BYTE_W;

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_byte[BYTE_W-1:HI_W] == '0);

  // R3
  unlocked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !locked && !rd_lo) |=> {hi_byte[HI_W-1:0], lo_byte} == $past(res_data));

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rd_hi) |=> ($stable(lo_byte) && $stable(hi_byte)));

  // R5
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !locked);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> done_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !res_valid) |=> !done_flag);
endmodule

bind adc_result_latch adc_result_latch_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr), .locked(locked),
  .lo_byte(lo_byte), .hi_byte(hi_byte), .done_flag(done_flag));

// File: tb/test_adc_result_latch.sv
module test_adc_result_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       rd_lo = 1'b0, rd_hi = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
  logic [7:0] lo_byte, hi_byte;
  logic       done_flag, irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_result_latch i_adc_result_latch (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr), .irq_en(irq_en),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .done_flag(done_flag), .irq(irq));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int pair();
    return {hi_byte, lo_byte};
  endfunction

  task automatic drive(input bit v, input int d, input bit lo, input bit hi, input bit clr);
    @(negedge clk);
    res_valid = v; res_data = d[9:0]; rd_lo = lo; rd_hi = hi; flag_clr = clr;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    res_valid = 0; rd_lo = 0; rd_hi = 0; flag_clr = 0;
  endtask

  task automatic step(input bit v, input int d, input bit lo, input bit hi, input bit clr);
    drive(v, d, lo, hi, clr);
    settle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ref_val;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pair", pair(), 0);
    chk("R1 reset flag", done_flag, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 sweep of all codes
    for (int d = 0; d < 1024; d++) begin
      step(1, d, 0, 0, 0);
      chk("R3 R2 mapping", pair(), ((d >> 8) << 8) | (d & 255));
      chk("R2 pad bits", hi_byte[7:2], 0);
      chk("R8 flag", done_flag, 1);
    end

    step(0, 0, 0, 0, 1);
    chk("R9 clear", done_flag, 0);

    // R4 R5 lock and release
    step(1, 10'h155, 0, 0, 0);
    ref_val = 16'h0155;
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0);
    for (int k = 0; k < 8; k++) begin
      step(1, 10'h2AA ^ k, 0, 0, 0);
      chk("R4 dropped while locked", pair(), ref_val);
      chk("R8 flag on dropped", done_flag, 1);
    end
    step(0, 0, 0, 1, 0);
    chk("R5 release keeps value", pair(), ref_val);
    step(1, 10'h0F0, 0, 0, 0);
    chk("R5 accepted after release", pair(), 16'h00F0);

    // R6 result with high read
    step(0, 0, 1, 0, 0);
    drive(1, 10'h3C3, 0, 1, 0);
    #1;
    chk("R6 old value on read", pair(), 16'h00F0);
    settle();
    chk("R6 new stored", pair(), 16'h03C3);
    step(1, 10'h201, 0, 0, 0);
    chk("R6 unlocked after", pair(), 16'h0201);

    // R7 result with low read
    step(0, 0, 0, 0, 1);
    step(1, 10'h111, 1, 0, 0);
    chk("R7 dropped", pair(), 16'h0201);
    chk("R7 flag", done_flag, 1);
    step(1, 10'h112, 0, 0, 0);
    chk("R7 still locked", pair(), 16'h0201);
    step(0, 0, 0, 1, 0);

    // R11 both strobes
    step(0, 0, 1, 1, 0);
    step(1, 10'h07E, 0, 0, 0);
    chk("R11 unlocked", pair(), 16'h007E);

    // R9 set wins
    step(0, 0, 0, 0, 1);
    chk("R9 clear", done_flag, 0);
    step(1, 10'h001, 0, 0, 1);
    chk("R9 set wins", done_flag, 1);

    // R10 interrupt gating
    irq_en = 0; #1;
    chk("R10 gated off", irq, 0);
    irq_en = 1; #1;
    chk("R10 enabled", irq, 1);
    step(0, 0, 0, 0, 1);
    chk("R10 cleared", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule